// File: doc/BRIEF.md
# Transmit Radio Mode Controller

This block is the mode controller of a transmit-only radio. It accepts one command strobe per cycle, the chip-select level, and two events from the packet path: packet complete and FIFO underflow. From these it moves through low-power, idle, synthesizer start-up, calibration, synthesizer-ready, transmit and underflow states. Every timed phase of the analog front end (synthesizer wake-up, PLL settling, calibration, crystal start-up) is modelled as a cycle count, and the counts are parameters so that a simulation can use short values.

Two static configuration inputs shape the flow. The calibration policy chooses whether the synthesizer is never calibrated automatically, calibrated on the way into transmit, calibrated on every automatic return to idle, or calibrated on every fourth automatic return. The post-packet selector chooses where transmit goes once a packet has been sent. The controller exposes a 5-bit numeric state code and enables for the crystal, synthesizer and power amplifier, plus an active-low ready flag for the crystal.

Top module: `tx_radio_ctrl`

## Requirements
- R1: After reset the state code is 1 (idle), the amplifier enable is 0 and the crystal enable is 1.
- R2: Strobes are coded on `strobe_cmd` as 0 reset, 1 idle, 2 transmit, 3 synth-on, 4 calibrate, 5 crystal-off, 6 power-down, 7 flush; the reset strobe moves any state to idle (code 1) on the next cycle and clears the fourth-return count and any pending power-down.
- R3: With policy 00, a transmit strobe in idle gives code 6 for WAKE_CYC cycles, then code 9 for SETTLE_CYC cycles, then code 19 with the amplifier enabled; the synthesizer enable is 1 from code 6 onward.
- R4: With policy 01, a synth-on or transmit strobe from idle inserts code 8 for CAL_CYC cycles between wake-up and settling; synth-on ends in code 18.
- R5: A packet-done event in transmit leads on the next cycle to idle when the post-packet selector is 00 (or 11), to code 18 when it is 01, and keeps code 19 when it is 10.
- R6: The idle strobe moves any state to idle on the next cycle and never starts a calibration, even when the policy calibrates on return.
- R7: With policy 10, every automatic return from transmit passes through code 12 for CAL_CYC cycles before idle, and entry into transmit takes no calibration.
- R8: With policy 11, the first three automatic returns go straight to idle and the fourth passes through code 12 for CAL_CYC cycles; the count then restarts.
- R9: The ready flag `ready_n` goes low XOSC_STABLE_CYC cycles after the crystal is switched on (after reset, or after leaving sleep or crystal-off), and goes high one cycle after entering sleep or crystal-off.
- R10: A FIFO underflow in transmit gives code 22 on the next cycle, taking priority over packet-done; code 22 ignores the transmit strobe and leaves only on a flush strobe (to idle) or an idle or reset strobe.
- R11: The crystal-off strobe gives code 2 with the crystal enable low only from idle and is ignored in other states; code 2 returns to idle one cycle after a falling edge on `csn`.
- R12: The power-down strobe in idle keeps code 1 until `csn` is high, then gives code 0 on the next cycle; a falling edge of `csn` in sleep returns to idle on the next cycle.
- R13: The calibrate strobe in idle gives code 4 for CAL_CYC cycles, then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_vld | input | 1 | A command strobe is present this cycle |
| strobe_cmd | input | 3 | Command code, see R2 |
| csn | input | 1 | Chip-select level, active low |
| pkt_done | input | 1 | One-cycle pulse: the current packet is complete |
| fifo_underflow | input | 1 | One-cycle pulse: the transmit FIFO ran dry mid-packet |
| autocal_sel | input | 2 | Calibration policy: 00 never, 01 on start, 10 on every return, 11 on every fourth return |
| txoff_sel | input | 2 | Post-packet destination: 00 idle, 01 synth-on, 10 transmit again |
| state_code | output | 5 | Numeric code of the current state |
| xosc_en | output | 1 | Crystal oscillator enable |
| synth_en | output | 1 | Frequency synthesizer enable |
| pa_en | output | 1 | Power amplifier enable |
| ready_n | output | 1 | Low once the crystal is considered stable |

## Verification
A strobe or event sampled at clock edge N changes `state_code` at edge N, so a state change is due one cycle after the stimulus; a timed phase entered at that edge holds for exactly its parameter count, so the code after wake-up is due WAKE_CYC+1 cycles after the strobe, the code after settling WAKE_CYC+SETTLE_CYC+1 cycles after it, and the ready flag falls XOSC_STABLE_CYC+1 cycles after leaving a low-power state. The bench records the cycle of each stimulus, queues every expected value with its due cycle, and a monitor on the falling edge compares the outputs when that cycle comes, also checking the cycle before a boundary to pin the length of each phase. An item whose cycle passes unseen counts as a failure.

// File: rtl/txrc_pkg.sv
package txrc_pkg;

  // State codes are visible on the state_code port.
  typedef enum logic [4:0] {
    ST_SLEEP   = 5'd0,
    ST_IDLE    = 5'd1,
    ST_XOFF    = 5'd2,
    ST_MANCAL  = 5'd4,
    ST_WAKE    = 5'd6,
    ST_CALPRE  = 5'd8,
    ST_SETTLE  = 5'd9,
    ST_CALPOST = 5'd12,
    ST_SYNTH   = 5'd18,
    ST_TX      = 5'd19,
    ST_UFLOW   = 5'd22
  } rstate_e;

  typedef enum logic [2:0] {
    CMD_RESET = 3'd0,
    CMD_IDLE  = 3'd1,
    CMD_TX    = 3'd2,
    CMD_SYNTH = 3'd3,
    CMD_CAL   = 3'd4,
    CMD_XOFF  = 3'd5,
    CMD_PWDN  = 3'd6,
    CMD_FLUSH = 3'd7
  } cmd_e;

  localparam logic [1:0] AC_NEVER  = 2'b00;
  localparam logic [1:0] AC_START  = 2'b01;
  localparam logic [1:0] AC_RETURN = 2'b10;
  localparam logic [1:0] AC_EVERYN = 2'b11;

  localparam logic [1:0] PP_IDLE  = 2'b00;
  localparam logic [1:0] PP_SYNTH = 2'b01;
  localparam logic [1:0] PP_TX    = 2'b10;

endpackage

// File: rtl/txrc_timer.sv
module txrc_timer #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;
  logic         cnt_en;

  assign cnt_en  = load | (cnt != '0);
  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= load ? load_val : (cnt - 1'b1);
    end
  end

  // R3
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/txrc_calpol.sv
module txrc_calpol #(
  parameter int RET_MOD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policy,
  input  logic       clr,
  input  logic       ret_evt,
  output logic       cal_on_start,
  output logic       cal_on_return
);
  import txrc_pkg::*;

  localparam int CW = (RET_MOD > 1) ? $clog2(RET_MOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(RET_MOD - 1);

  logic [CW-1:0] cnt;
  logic          cnt_en;
  logic          at_last;

  assign at_last       = (cnt == LAST);
  assign cnt_en        = clr | (ret_evt & (policy == AC_EVERYN));
  assign cal_on_start  = (policy == AC_START);
  assign cal_on_return = (policy == AC_RETURN) | ((policy == AC_EVERYN) & at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      if (clr || at_last) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end

  // R8
  count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ret_evt) |=> $stable(cnt));

endmodule

// File: rtl/txrc_xosc.sv
module txrc_xosc #(
  parameter int STABLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_off,
  output logic ready_n
);

  localparam int XW = $clog2(STABLE_CYC + 1);
  localparam logic [XW-1:0] START = XW'(STABLE_CYC - 1);

  logic [XW-1:0] cnt;
  logic          ok;
  logic          en;

  assign en      = osc_off | ~ok;
  assign ready_n = ~ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= START;
      ok  <= 1'b0;
    end else if (en) begin
      if (osc_off) begin
        cnt <= START;
        ok  <= 1'b0;
      end else if (cnt == '0) begin
        ok  <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R9
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |=> ready_n);

endmodule

// File: rtl/tx_radio_ctrl.sv
module tx_radio_ctrl #(
  parameter int WAKE_CYC        = 1149,
  parameter int SETTLE_CYC      = 1149,
  parameter int CAL_CYC         = 18739,
  parameter int XOSC_STABLE_CYC = 1000,
  parameter int RET_MOD         = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_vld,
  input  logic [2:0] strobe_cmd,
  input  logic       csn,
  input  logic       pkt_done,
  input  logic       fifo_underflow,
  input  logic [1:0] autocal_sel,
  input  logic [1:0] txoff_sel,
  output logic [4:0] state_code,
  output logic       xosc_en,
  output logic       synth_en,
  output logic       pa_en,
  output logic       ready_n
);
  import txrc_pkg::*;

  localparam int MAX_WS = (WAKE_CYC > SETTLE_CYC) ? WAKE_CYC : SETTLE_CYC;
  localparam int MAXD   = (MAX_WS > CAL_CYC) ? MAX_WS : CAL_CYC;
  localparam int CNT_W  = $clog2(MAXD + 1);
  localparam logic [CNT_W-1:0] D_WAKE   = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] D_SETTLE = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] D_CAL    = CNT_W'(CAL_CYC - 1);

  rstate_e state, state_n;
  logic    tgt_tx, tgt_tx_n;
  logic    pend, pend_n;
  logic    csn_q;
  logic    csn_fall;
  logic    st_en;
  logic    ret_evt;
  logic    clr_cnt;
  logic    tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic    tmr_done;
  logic    cal_on_start, cal_on_return;
  logic    s_reset, s_idle, s_tx, s_synth, s_cal, s_xoff, s_pwdn, s_flush;

  assign s_reset = strobe_vld & (strobe_cmd == CMD_RESET);
  assign s_idle  = strobe_vld & (strobe_cmd == CMD_IDLE);
  assign s_tx    = strobe_vld & (strobe_cmd == CMD_TX);
  assign s_synth = strobe_vld & (strobe_cmd == CMD_SYNTH);
  assign s_cal   = strobe_vld & (strobe_cmd == CMD_CAL);
  assign s_xoff  = strobe_vld & (strobe_cmd == CMD_XOFF);
  assign s_pwdn  = strobe_vld & (strobe_cmd == CMD_PWDN);
  assign s_flush = strobe_vld & (strobe_cmd == CMD_FLUSH);

  assign csn_fall = csn_q & ~csn;
  assign clr_cnt  = s_reset;

  // Next-state logic
  always_comb begin
    state_n  = state;
    tgt_tx_n = tgt_tx;
    pend_n   = pend;
    ret_evt  = 1'b0;
    if (s_reset || s_idle) begin
      state_n = ST_IDLE;
      pend_n  = 1'b0;
    end else begin
      unique case (state)
        ST_SLEEP, ST_XOFF: begin
          if (csn_fall) state_n = ST_IDLE;
        end
        ST_IDLE: begin
          if (s_tx) begin
            state_n  = ST_WAKE;
            tgt_tx_n = 1'b1;
          end else if (s_synth) begin
            state_n  = ST_WAKE;
            tgt_tx_n = 1'b0;
          end else if (s_cal) begin
            state_n = ST_MANCAL;
          end else if (s_xoff) begin
            state_n = ST_XOFF;
          end else if (s_pwdn) begin
            pend_n = 1'b1;
          end else if (pend && csn) begin
            state_n = ST_SLEEP;
          end
        end
        ST_WAKE: begin
          if (tmr_done) state_n = cal_on_start ? ST_CALPRE : ST_SETTLE;
        end
        ST_CALPRE: begin
          if (tmr_done) state_n = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (tmr_done) state_n = tgt_tx ? ST_TX : ST_SYNTH;
        end
        ST_SYNTH: begin
          if (s_tx) state_n = ST_TX;
        end
        ST_TX: begin
          if (fifo_underflow) begin
            state_n = ST_UFLOW;
          end else if (pkt_done) begin
            if (txoff_sel == PP_SYNTH) begin
              state_n = ST_SYNTH;
            end else if (txoff_sel == PP_TX) begin
              state_n = ST_TX;
            end else begin
              ret_evt = 1'b1;
              state_n = cal_on_return ? ST_CALPOST : ST_IDLE;
            end
          end
        end
        ST_CALPOST, ST_MANCAL: begin
          if (tmr_done) state_n = ST_IDLE;
        end
        ST_UFLOW: begin
          if (s_flush) state_n = ST_IDLE;
        end
        default: state_n = ST_IDLE;
      endcase
      if (state_n != ST_IDLE) pend_n = 1'b0;
    end
  end

  // Timer load on entry into a timed state
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_n != state) begin
      unique case (state_n)
        ST_WAKE: begin
          tmr_load = 1'b1;
          tmr_val  = D_WAKE;
        end
        ST_SETTLE: begin
          tmr_load = 1'b1;
          tmr_val  = D_SETTLE;
        end
        ST_CALPRE, ST_CALPOST, ST_MANCAL: begin
          tmr_load = 1'b1;
          tmr_val  = D_CAL;
        end
        default: ;
      endcase
    end
  end

  assign st_en = (state_n != state) | (tgt_tx_n != tgt_tx) | (pend_n != pend);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tgt_tx <= 1'b0;
      pend   <= 1'b0;
    end else if (st_en) begin
      state  <= state_n;
      tgt_tx <= tgt_tx_n;
      pend   <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csn_q <= 1'b1;
    else        csn_q <= csn;
  end

  txrc_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  txrc_calpol #(.RET_MOD(RET_MOD)) u_calpol (
    .clk           (clk),
    .rst_n         (rst_n),
    .policy        (autocal_sel),
    .clr           (clr_cnt),
    .ret_evt       (ret_evt),
    .cal_on_start  (cal_on_start),
    .cal_on_return (cal_on_return)
  );

  txrc_xosc #(.STABLE_CYC(XOSC_STABLE_CYC)) u_xosc (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_off (~xosc_en),
    .ready_n (ready_n)
  );

  assign state_code = state;
  assign xosc_en    = (state != ST_SLEEP) && (state != ST_XOFF);
  assign pa_en      = (state == ST_TX);
  assign synth_en   = (state == ST_WAKE) || (state == ST_CALPRE) || (state == ST_SETTLE) ||
                      (state == ST_SYNTH) || (state == ST_TX);

  // R6
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_idle |=> (state_code == 5'd1));

  // R10
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UFLOW && !s_flush && !s_idle && !s_reset) |=> (state_code == 5'd22));

  // R11
  xoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_xoff && state != ST_IDLE && state != ST_XOFF) |=> (state_code != 5'd2));

  // R5
  post_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && pkt_done && !fifo_underflow && !strobe_vld && txoff_sel == PP_SYNTH)
      |=> (state_code == 5'd18));

  // R12
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && pend && csn && !strobe_vld) |=> (state_code == 5'd0));

endmodule

// File: tb/tb_tx_radio_ctrl.sv
`timescale 1ns/1ps
module tb_tx_radio_ctrl;
  import txrc_pkg::*;

  localparam int WK = 5;
  localparam int ST = 7;
  localparam int CL = 20;
  localparam int XS = 6;
  localparam int TXD = WK + ST + 1;

  logic       clk;
  logic       rst_n;
  logic       strobe_vld;
  logic [2:0] strobe_cmd;
  logic       csn;
  logic       pkt_done;
  logic       fifo_underflow;
  logic [1:0] autocal_sel;
  logic [1:0] txoff_sel;
  logic [4:0] state_code;
  logic       xosc_en, synth_en, pa_en, ready_n;

  tx_radio_ctrl #(
    .WAKE_CYC(WK), .SETTLE_CYC(ST), .CAL_CYC(CL), .XOSC_STABLE_CYC(XS), .RET_MOD(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .strobe_vld(strobe_vld), .strobe_cmd(strobe_cmd),
    .csn(csn), .pkt_done(pkt_done), .fifo_underflow(fifo_underflow),
    .autocal_sel(autocal_sel), .txoff_sel(txoff_sel), .state_code(state_code),
    .xosc_en(xosc_en), .synth_en(synth_en), .pa_en(pa_en), .ready_n(ready_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc;
  int base;
  int n_run;
  int n_fail;
  bit done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct {
    int    due;
    int    kind;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];

  task automatic push(int dly, int kind, int val, string tag);
    exp_t it;
    int   i;
    it = '{due: base + dly, kind: kind, val: val, tag: tag};
    i = 0;
    while (i < q.size() && q[i].due <= it.due) i++;
    q.insert(i, it);
  endtask

  function automatic int sample(int kind);
    case (kind)
      0:       return int'(state_code);
      1:       return int'(ready_n);
      2:       return int'(pa_en);
      3:       return int'(xosc_en);
      default: return int'(synth_en);
    endcase
  endfunction

  // Monitor: compares queued items at their due cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t it;
        int   got;
        it = q.pop_front();
        n_run++;
        if (it.due < cyc) begin
          n_fail++;
          $display("FAIL %s: item missed at cycle %0d, actual none expected %0d", it.tag, cyc, it.val);
        end else begin
          got = sample(it.kind);
          if (got != it.val) begin
            n_fail++;
            $display("FAIL %s: kind %0d cycle %0d actual %0d expected %0d",
                     it.tag, it.kind, cyc, got, it.val);
          end
        end
      end
    end
  end

  task automatic drive_cmd(cmd_e c);
    @(negedge clk);
    strobe_vld = 1'b1;
    strobe_cmd = c;
    base = cyc;
  endtask

  task automatic drive_evt(bit pd, bit uf);
    @(negedge clk);
    pkt_done       = pd;
    fifo_underflow = uf;
    base = cyc;
  endtask

  task automatic drive_csn(bit v);
    @(negedge clk);
    csn  = v;
    base = cyc;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) begin
      @(negedge clk);
      strobe_vld     = 1'b0;
      pkt_done       = 1'b0;
      fifo_underflow = 1'b0;
    end
  endtask

  task automatic go_tx();
    drive_cmd(CMD_TX);
    push(TXD, 0, 19, "R3 reach transmit");
    wait_cyc(TXD + 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    done = 1'b0; n_run = 0; n_fail = 0; base = 0;
    rst_n = 1'b0; strobe_vld = 1'b0; strobe_cmd = 3'd0; csn = 1'b0;
    pkt_done = 1'b0; fifo_underflow = 1'b0; autocal_sel = AC_NEVER; txoff_sel = PP_IDLE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base = 0;
    // R1 / R9 reset state and crystal ready
    push(1, 0, 1, "R1 state after reset");
    push(1, 2, 0, "R1 pa off");
    push(1, 3, 1, "R1 crystal on");
    push(XS - 1, 1, 1, "R9 not ready yet");
    push(XS, 1, 0, "R9 ready after reset");
    wait_cyc(XS + 2);

    // R3 idle to transmit without calibration
    drive_cmd(CMD_TX);
    push(1, 0, 6, "R3 wake");
    push(1, 4, 1, "R3 synth on");
    push(WK, 0, 6, "R3 wake length");
    push(WK + 1, 0, 9, "R3 settle");
    push(WK + ST, 0, 9, "R3 settle length");
    push(TXD, 0, 19, "R3 transmit");
    push(TXD, 2, 1, "R3 pa on");
    wait_cyc(TXD + 1);
    drive_evt(1'b1, 1'b0);
    push(1, 0, 1, "R5 selector 00 to idle");
    push(1, 2, 0, "R5 pa off");
    wait_cyc(3);

    // R4 calibration on start, synth-on path
    autocal_sel = AC_START;
    drive_cmd(CMD_SYNTH);
    push(1, 0, 6, "R4 wake");
    push(WK + 1, 0, 8, "R4 calibrate");
    push(WK + CL, 0, 8, "R4 calibrate length");
    push(WK + CL + 1, 0, 9, "R4 settle");
    push(WK + CL + ST + 1, 0, 18, "R4 synth ready");
    wait_cyc(WK + CL + ST + 2);
    drive_cmd(CMD_TX);
    push(1, 0, 19, "R4 transmit from synth-on");
    wait_cyc(2);
    txoff_sel = PP_SYNTH;
    drive_evt(1'b1, 1'b0);
    push(1, 0, 18, "R5 selector 01 to synth-on");
    wait_cyc(2);
    drive_cmd(CMD_TX);
    push(1, 0, 19, "R5 back to transmit");
    wait_cyc(2);
    txoff_sel = PP_TX;
    drive_evt(1'b1, 1'b0);
    push(1, 0, 19, "R5 selector 10 stays transmit");
    push(2, 0, 19, "R5 selector 10 holds");
    wait_cyc(3);
    txoff_sel = PP_IDLE;

    // R6 idle strobe from transmit, no calibration
    autocal_sel = AC_RETURN;
    drive_cmd(CMD_IDLE);
    push(1, 0, 1, "R6 idle strobe");
    push(2, 0, 1, "R6 no calibration");
    wait_cyc(3);

    // R7 calibrate on every return
    drive_cmd(CMD_TX);
    push(WK + 1, 0, 9, "R7 no calibration on entry");
    push(TXD, 0, 19, "R7 transmit");
    wait_cyc(TXD + 1);
    drive_evt(1'b1, 1'b0);
    push(1, 0, 12, "R7 calibrate on return");
    push(CL, 0, 12, "R7 calibrate length");
    push(CL + 1, 0, 1, "R7 idle after calibration");
    wait_cyc(CL + 2);

    // R8 every fourth return
    autocal_sel = AC_EVERYN;
    for (int k = 0; k < 3; k++) begin
      go_tx();
      drive_evt(1'b1, 1'b0);
      push(1, 0, 1, "R8 early return straight to idle");
      wait_cyc(2);
    end
    go_tx();
    drive_evt(1'b1, 1'b0);
    push(1, 0, 12, "R8 fourth return calibrates");
    push(CL + 1, 0, 1, "R8 idle after calibration");
    wait_cyc(CL + 2);
    go_tx();
    drive_evt(1'b1, 1'b0);
    push(1, 0, 1, "R8 count restarted");
    wait_cyc(2);
    autocal_sel = AC_NEVER;

    // R10 underflow
    go_tx();
    drive_evt(1'b1, 1'b1);
    push(1, 0, 22, "R10 underflow beats packet-done");
    wait_cyc(2);
    drive_cmd(CMD_TX);
    push(1, 0, 22, "R10 transmit strobe ignored");
    wait_cyc(2);
    drive_cmd(CMD_FLUSH);
    push(1, 0, 1, "R10 flush to idle");
    wait_cyc(2);

    // R11 crystal-off
    go_tx();
    drive_cmd(CMD_XOFF);
    push(1, 0, 19, "R11 crystal-off ignored in transmit");
    wait_cyc(2);
    drive_cmd(CMD_IDLE);
    wait_cyc(2);
    drive_cmd(CMD_XOFF);
    push(1, 0, 2, "R11 crystal-off from idle");
    push(1, 3, 0, "R11 crystal disabled");
    push(2, 1, 1, "R9 ready cleared");
    wait_cyc(3);
    drive_csn(1'b1);
    push(1, 0, 2, "R11 stays on csn high");
    wait_cyc(2);
    drive_csn(1'b0);
    push(1, 0, 1, "R11 csn fall to idle");
    push(XS, 1, 1, "R9 not ready yet after wake");
    push(XS + 1, 1, 0, "R9 ready after wake");
    wait_cyc(XS + 2);

    // R12 power-down
    drive_cmd(CMD_PWDN);
    push(1, 0, 1, "R12 waits for csn high");
    push(2, 0, 1, "R12 still idle");
    wait_cyc(3);
    drive_csn(1'b1);
    push(1, 0, 0, "R12 sleep");
    push(1, 3, 0, "R12 crystal off");
    wait_cyc(3);
    drive_csn(1'b0);
    push(1, 0, 1, "R12 wake to idle");
    push(XS + 1, 1, 0, "R9 ready after sleep");
    wait_cyc(XS + 2);

    // R13 manual calibration
    drive_cmd(CMD_CAL);
    push(1, 0, 4, "R13 manual calibration");
    push(CL, 0, 4, "R13 calibration length");
    push(CL + 1, 0, 1, "R13 back to idle");
    wait_cyc(CL + 2);

    // R2 reset strobe
    drive_cmd(CMD_SYNTH);
    push(TXD, 0, 18, "R2 synth-on before reset strobe");
    wait_cyc(TXD + 1);
    drive_cmd(CMD_RESET);
    push(1, 0, 1, "R2 reset strobe to idle");
    wait_cyc(2);

    wait_cyc(2);
    if (q.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL queue: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end

endmodule